// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a processor that executes each instruction over several clock cycles. The processor shares one memory for instructions and data, and one ALU for address, branch and arithmetic work. Every instruction starts with the same two steps. A fetch step loads the instruction register and advances the program counter by four. A decode step reads both source registers. In the same decode step the ALU adds the shifted, sign-extended offset to the program counter, so a branch target is ready in case the instruction needs it. The 6-bit opcode held in the instruction register then steers the machine onto a path for its instruction class. These paths take three to five cycles in total.

The outputs are a function of the current state alone. They drive the datapath's multiplexer selects, write enables and ALU mode. The ALU, the register file, the instruction register and the ALU function decoder sit outside the block. Each step uses the memory, the register file or the ALU for at most one operation. When a class finishes, the machine goes back to fetch. A reset also puts the machine in fetch.

Top module: `mcycle_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. After any clock edge that samples `rst` high, the machine is in the fetch state, and this holds even in the middle of an instruction.
- R2: The fetch state drives `memRd`=1, `instLoad`=1, `pcLoad`=1 and `aluBSel`=01 (constant four), with every other output 0 (`pcSel`=00 picks the ALU result, `aluMode`=00 adds, `aluASel`=0 picks the PC). The state after fetch is always decode.
- R3: The decode state drives `aluBSel`=11 (shifted sign-extended offset), with every other output 0, so the ALU adds PC + (offset<<2) and nothing is written.
- R4: In decode the opcode picks the next state. 100011 (load) and 101011 (store) go to address compute, 000000 (register-register) goes to execute, 000100 (branch-if-equal) goes to branch, and 000010 (jump) goes to jump.
- R5: Any other opcode in decode sends the machine back to fetch on the next clock. The path it takes, decode and then fetch, asserts no memory write, register write or PC write.
- R6: The address-compute state drives `aluASel`=1 and `aluBSel`=10 (sign-extended offset), with every other output 0. It is followed by memory read for opcode 100011 and by memory write for opcode 101011.
- R7: A load takes 5 cycles. After address compute comes memory read (`memRd`=1, `addrFromAlu`=1), then write-back (`rfWrite`=1, `wbFromMem`=1, `rfDestRd`=0, which selects rt), then fetch.
- R8: A store takes 4 cycles. After address compute comes memory write (`memWr`=1, `addrFromAlu`=1), then fetch.
- R9: A register-register instruction takes 4 cycles. Execute drives `aluASel`=1, `aluBSel`=00 and `aluMode`=10 (function field). It is followed by write-back (`rfWrite`=1, `rfDestRd`=1, which selects rd, and `wbFromMem`=0), then fetch.
- R10: A branch takes 3 cycles. Its third state drives `aluASel`=1, `aluBSel`=00, `aluMode`=01 (subtract), `pcLoadIfZero`=1 and `pcSel`=01 (the ALU output register), then fetch.
- R11: A jump takes 3 cycles. Its third state drives `pcLoad`=1 and `pcSel`=10 (upper four PC bits joined to the instruction's low 26 bits shifted left by two), then fetch.
- R12: In every cycle, at most one of `memRd`, `memWr` and `rfWrite` is high, and `pcLoad` and `pcLoadIfZero` are never high together.
- R13: The outputs depend only on the state. A change of `opcode` while the machine is in execute, branch or jump leaves the outputs of that cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pcLoad | output | 1 | Unconditional program counter write |
| pcLoadIfZero | output | 1 | Program counter write qualified by the ALU zero flag |
| addrFromAlu | output | 1 | Memory address from the ALU output register (0: from PC) |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| instLoad | output | 1 | Instruction register load |
| wbFromMem | output | 1 | Register write data from the memory data register (0: from ALU output register) |
| pcSel | output | 2 | Next-PC source: 00 ALU, 01 ALU output register, 10 jump target |
| aluMode | output | 2 | ALU mode: 00 add, 01 subtract, 10 by function field |
| aluASel | output | 1 | ALU operand A: 0 PC, 1 register A |
| aluBSel | output | 2 | ALU operand B: 00 register B, 01 four, 10 offset, 11 offset<<2 |
| rfWrite | output | 1 | Register file write strobe |
| rfDestRd | output | 1 | Destination register: 1 rd, 0 rt |

## Verification
The bench runs each instruction class and compares the output vector cycle by cycle against the class's expected path. A design with a wrong dispatch or a missing state shows up as an unexpected vector, or as a path that is one cycle too long or too short. Opcodes one bit away from a legal code must return to fetch after decode. A design that decodes only part of the opcode would instead start a load, store or branch path. A reset raised during a load must land in fetch, where a design that ignores it would go on to the memory read. The opcode is also changed during the execute, branch and jump states. This catches a design whose outputs or completion paths look at the opcode after decode.

// File: rtl/mcycle_ctrl_pkg.sv
package mcycle_ctrl_pkg;

  localparam int STATE_COUNT = 10;
  localparam int STATE_W     = $clog2(STATE_COUNT);

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH   = 'd0,
    ST_DECODE  = 'd1,
    ST_ADDR    = 'd2,
    ST_LDREAD  = 'd3,
    ST_LDWB    = 'd4,
    ST_STWRITE = 'd5,
    ST_EXEC    = 'd6,
    ST_ALUWB   = 'd7,
    ST_BRANCH  = 'd8,
    ST_JUMP    = 'd9
  } ctlState_e;

  localparam logic [1:0] PC_FROM_ALU    = 2'b00;
  localparam logic [1:0] PC_FROM_ALUOUT = 2'b01;
  localparam logic [1:0] PC_FROM_JUMP   = 2'b10;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;

  localparam logic [1:0] B_FROM_REG   = 2'b00;
  localparam logic [1:0] B_FROM_FOUR  = 2'b01;
  localparam logic [1:0] B_FROM_IMM   = 2'b10;
  localparam logic [1:0] B_FROM_IMMSH = 2'b11;

  typedef struct packed {
    logic       pcLoad;
    logic       pcLoadIfZero;
    logic       addrFromAlu;
    logic       memRd;
    logic       memWr;
    logic       instLoad;
    logic       wbFromMem;
    logic [1:0] pcSel;
    logic [1:0] aluMode;
    logic       aluASel;
    logic [1:0] aluBSel;
    logic       rfWrite;
    logic       rfDestRd;
  } strobes_t;

endpackage

// File: rtl/mcycle_ctrl_seq.sv
module mcycle_ctrl_seq
  import mcycle_ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output ctlState_e       state
);

  logic isLoad, isStore, isRtype, isBranch, isJump, isKnown;
  ctlState_e nextState;

  assign isLoad   = (opcode == OP_LOAD);
  assign isStore  = (opcode == OP_STORE);
  assign isRtype  = (opcode == OP_RTYPE);
  assign isBranch = (opcode == OP_BRANCH);
  assign isJump   = (opcode == OP_JUMP);
  assign isKnown  = isLoad | isStore | isRtype | isBranch | isJump;

  always_comb begin
    nextState = ST_FETCH;
    case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        if (isLoad || isStore) nextState = ST_ADDR;
        else if (isRtype)      nextState = ST_EXEC;
        else if (isBranch)     nextState = ST_BRANCH;
        else if (isJump)       nextState = ST_JUMP;
        else                   nextState = ST_FETCH;
      end
      ST_ADDR:   nextState = isStore ? ST_STWRITE : ST_LDREAD;
      ST_LDREAD: nextState = ST_LDWB;
      ST_EXEC:   nextState = ST_ALUWB;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  // R2: fetch always hands over to decode
  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  // R5: an opcode outside the known set goes straight back to fetch
  p_unknown_to_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !isKnown) |=> (state == ST_FETCH));

  // R6: address compute is followed by a memory access state
  p_addr_then_mem_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |=> (state == ST_LDREAD || state == ST_STWRITE));

  // R7: a load's memory read is followed by its write-back
  p_ldread_then_wb_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LDREAD) |=> (state == ST_LDWB));

  // R11: completion states return to fetch
  p_complete_to_fetch_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LDWB || state == ST_STWRITE || state == ST_ALUWB ||
     state == ST_BRANCH || state == ST_JUMP) |=> (state == ST_FETCH));

endmodule

// File: rtl/mcycle_ctrl_dec.sv
module mcycle_ctrl_dec
  import mcycle_ctrl_pkg::*;
(
  input  ctlState_e state,
  output strobes_t  strobes
);

  always_comb begin
    strobes = '0;
    case (state)
      ST_FETCH: begin
        strobes.memRd    = 1'b1;
        strobes.instLoad = 1'b1;
        strobes.pcLoad   = 1'b1;
        strobes.pcSel    = PC_FROM_ALU;
        strobes.aluMode  = ALU_ADD;
        strobes.aluBSel  = B_FROM_FOUR;
      end
      ST_DECODE: begin
        strobes.aluMode = ALU_ADD;
        strobes.aluBSel = B_FROM_IMMSH;
      end
      ST_ADDR: begin
        strobes.aluASel = 1'b1;
        strobes.aluBSel = B_FROM_IMM;
        strobes.aluMode = ALU_ADD;
      end
      ST_LDREAD: begin
        strobes.memRd       = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      ST_LDWB: begin
        strobes.rfWrite   = 1'b1;
        strobes.wbFromMem = 1'b1;
      end
      ST_STWRITE: begin
        strobes.memWr       = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      ST_EXEC: begin
        strobes.aluASel = 1'b1;
        strobes.aluBSel = B_FROM_REG;
        strobes.aluMode = ALU_FUNCT;
      end
      ST_ALUWB: begin
        strobes.rfWrite  = 1'b1;
        strobes.rfDestRd = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluASel      = 1'b1;
        strobes.aluBSel      = B_FROM_REG;
        strobes.aluMode      = ALU_SUB;
        strobes.pcLoadIfZero = 1'b1;
        strobes.pcSel        = PC_FROM_ALUOUT;
      end
      ST_JUMP: begin
        strobes.pcLoad = 1'b1;
        strobes.pcSel  = PC_FROM_JUMP;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mcycle_ctrl.sv
module mcycle_ctrl
  import mcycle_ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pcLoad,
  output logic            pcLoadIfZero,
  output logic            addrFromAlu,
  output logic            memRd,
  output logic            memWr,
  output logic            instLoad,
  output logic            wbFromMem,
  output logic [1:0]      pcSel,
  output logic [1:0]      aluMode,
  output logic            aluASel,
  output logic [1:0]      aluBSel,
  output logic            rfWrite,
  output logic            rfDestRd
);

  ctlState_e curState;
  strobes_t  ctlStrobes;

  mcycle_ctrl_seq #(
    .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) seqInst (
    .clk(clk), .rst(rst), .opcode(opcode), .state(curState)
  );

  mcycle_ctrl_dec decInst (
    .state(curState), .strobes(ctlStrobes)
  );

  assign pcLoad       = ctlStrobes.pcLoad;
  assign pcLoadIfZero = ctlStrobes.pcLoadIfZero;
  assign addrFromAlu  = ctlStrobes.addrFromAlu;
  assign memRd        = ctlStrobes.memRd;
  assign memWr        = ctlStrobes.memWr;
  assign instLoad     = ctlStrobes.instLoad;
  assign wbFromMem    = ctlStrobes.wbFromMem;
  assign pcSel        = ctlStrobes.pcSel;
  assign aluMode      = ctlStrobes.aluMode;
  assign aluASel      = ctlStrobes.aluASel;
  assign aluBSel      = ctlStrobes.aluBSel;
  assign rfWrite      = ctlStrobes.rfWrite;
  assign rfDestRd     = ctlStrobes.rfDestRd;

  // R12: one storage access per cycle
  p_single_access_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memRd, memWr, rfWrite}));

  // R12: conditional and unconditional PC writes never overlap
  p_pc_write_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(pcLoad && pcLoadIfZero));

  // R3: a cycle that loads the instruction is followed by one that writes nothing
  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    instLoad |=> !(memWr || rfWrite || pcLoad || pcLoadIfZero));

endmodule

// File: tb/mcycle_ctrl_test.sv
`timescale 1ns/1ps
module mcycle_ctrl_test;

  localparam int HALF = 2;

  localparam int S_FETCH = 0, S_DECODE = 1, S_ADDR = 2, S_LDREAD = 3,
                 S_LDWB = 4, S_STWRITE = 5, S_EXEC = 6, S_ALUWB = 7,
                 S_BRANCH = 8, S_JUMP = 9;

  localparam logic [5:0] C_RTYPE  = 6'b000000;
  localparam logic [5:0] C_LOAD   = 6'b100011;
  localparam logic [5:0] C_STORE  = 6'b101011;
  localparam logic [5:0] C_BRANCH = 6'b000100;
  localparam logic [5:0] C_JUMP   = 6'b000010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic       pcLoad, pcLoadIfZero, addrFromAlu, memRd, memWr, instLoad;
  logic       wbFromMem, aluASel, rfWrite, rfDestRd;
  logic [1:0] pcSel, aluMode, aluBSel;
  logic [15:0] actVec;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  benchDone = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #HALF clk = ~clk;

  mcycle_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pcLoad(pcLoad), .pcLoadIfZero(pcLoadIfZero), .addrFromAlu(addrFromAlu),
    .memRd(memRd), .memWr(memWr), .instLoad(instLoad), .wbFromMem(wbFromMem),
    .pcSel(pcSel), .aluMode(aluMode), .aluASel(aluASel), .aluBSel(aluBSel),
    .rfWrite(rfWrite), .rfDestRd(rfDestRd)
  );

  assign actVec = {pcLoad, pcLoadIfZero, addrFromAlu, memRd, memWr, instLoad,
                   wbFromMem, pcSel, aluMode, aluASel, aluBSel, rfWrite, rfDestRd};

  function automatic logic [15:0] mk(input logic pL, input logic pZ, input logic aF,
      input logic mR, input logic mW, input logic iL, input logic wM,
      input logic [1:0] pS, input logic [1:0] aM, input logic aA,
      input logic [1:0] aB, input logic rW, input logic rD);
    return {pL, pZ, aF, mR, mW, iL, wM, pS, aM, aA, aB, rW, rD};
  endfunction

  function automatic logic [15:0] expVec(input int s);
    case (s)
      S_FETCH:   return mk(1,0,0,1,0,1,0,2'b00,2'b00,0,2'b01,0,0);
      S_DECODE:  return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0);
      S_ADDR:    return mk(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
      S_LDREAD:  return mk(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0);
      S_LDWB:    return mk(0,0,0,0,0,0,1,2'b00,2'b00,0,2'b00,1,0);
      S_STWRITE: return mk(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0);
      S_EXEC:    return mk(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0);
      S_ALUWB:   return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1);
      S_BRANCH:  return mk(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0);
      default:   return mk(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0);
    endcase
  endfunction

  function automatic string stateTag(input int s);
    case (s)
      S_FETCH:                return "R2";
      S_DECODE:               return "R3";
      S_ADDR:                 return "R6";
      S_LDREAD, S_LDWB:       return "R7";
      S_STWRITE:              return "R8";
      S_EXEC, S_ALUWB:        return "R9";
      S_BRANCH:               return "R10";
      default:                return "R11";
    endcase
  endfunction

  task automatic pushPath(input logic [5:0] op, input string tag, output int n);
    int path[$];
    path = '{S_FETCH, S_DECODE};
    case (op)
      C_LOAD:   path = {path, S_ADDR, S_LDREAD, S_LDWB};
      C_STORE:  path = {path, S_ADDR, S_STWRITE};
      C_RTYPE:  path = {path, S_EXEC, S_ALUWB};
      C_BRANCH: path = {path, S_BRANCH};
      C_JUMP:   path = {path, S_JUMP};
      default:  ;
    endcase
    foreach (path[i]) begin
      expQ.push_back(expVec(path[i]));
      tagQ.push_back({tag, "/", stateTag(path[i])});
    end
    n = path.size();
  endtask

  // Called just after a rising edge while the design is in fetch.
  task automatic runInstr(input logic [5:0] op, input bit scramble, input string tag);
    int n;
    opcode = op;
    pushPath(op, tag, n);
    if (scramble) begin
      repeat (2) @(posedge clk);
      #1 opcode = ~op;
      repeat (n - 2) @(posedge clk);
    end else begin
      repeat (n) @(posedge clk);
    end
    #1;
  endtask

  // Monitor: pops expected vectors, compares mid-cycle.
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      testsRun++;
      if (!$onehot0({memRd, memWr, rfWrite}) || (pcLoad && pcLoadIfZero)) begin
        testsFailed++;
        $display("FAIL R12 exclusive strobes actual=%b expected=at most one access", actVec);
      end
    end
    if (expQ.size() != 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      testsRun++;
      if (actVec !== e) begin
        testsFailed++;
        $display("FAIL %s output vector actual=%b expected=%b", t, actVec, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!benchDone) begin
      testsFailed++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset state
    repeat (2) @(posedge clk);
    #(HALF + 1);
    testsRun++;
    if (actVec !== expVec(S_FETCH)) begin
      testsFailed++;
      $display("FAIL R1 reset vector actual=%b expected=%b", actVec, expVec(S_FETCH));
    end
    @(posedge clk);
    #1 rst = 1'b0;

    // R4 dispatch of each class
    runInstr(C_LOAD,   1'b0, "R4");
    runInstr(C_STORE,  1'b0, "R4");
    runInstr(C_RTYPE,  1'b0, "R4");
    runInstr(C_BRANCH, 1'b0, "R4");
    runInstr(C_JUMP,   1'b0, "R4");

    // R5 unknown opcodes, including near misses of legal codes
    runInstr(6'b111111, 1'b0, "R5");
    runInstr(6'b100010, 1'b0, "R5");
    runInstr(6'b000110, 1'b0, "R5");
    runInstr(6'b101001, 1'b0, "R5");

    // R13 opcode changes after decode have no effect
    runInstr(C_RTYPE,  1'b1, "R13");
    runInstr(C_BRANCH, 1'b1, "R13");
    runInstr(C_JUMP,   1'b1, "R13");

    // R1 reset in the middle of a load
    opcode = C_LOAD;
    expQ.push_back(expVec(S_FETCH));  tagQ.push_back("R1/R2");
    expQ.push_back(expVec(S_DECODE)); tagQ.push_back("R1/R3");
    expQ.push_back(expVec(S_ADDR));   tagQ.push_back("R1/R6");
    repeat (2) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    runInstr(C_STORE, 1'b0, "R1");

    // Back-to-back mixed stream: R7 R8 R9 R10 R11
    for (int k = 0; k < 3; k++) begin
      runInstr(C_LOAD,   1'b0, "R7");
      runInstr(C_BRANCH, 1'b0, "R10");
      runInstr(C_STORE,  1'b0, "R8");
      runInstr(C_JUMP,   1'b0, "R11");
      runInstr(C_RTYPE,  1'b0, "R9");
    end

    @(negedge clk);
    #2;
    testsRun++;
    n = expQ.size();
    if (n != 0) begin
      testsFailed++;
      $display("FAIL R2 leftover expectations actual=%0d expected=0", n);
    end
    benchDone = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule